// File: doc/BRIEF.md
# Offset Gray Pointer Counter

This block is a wrapping pointer for a buffer whose depth is even but is not required to be a power of two. The pointer is meant to be passed to another clock domain, so every increment must change exactly one bit of the value that crosses. That includes the step from the last entry back to the first. A plain Gray counter over 2^N codes cannot give this for a depth such as 688. This counter therefore runs its binary count over a contiguous window of DEPTH values placed at the centre of the 2^N space. The window starts at 2^N/2 − DEPTH/2 and ends at 2^N/2 + DEPTH/2 − 1. Because of this placement, the codes of the two window ends are mirror images that differ only in the top Gray bit.

The binary value and its Gray image are both held in flip-flops. The Gray register is loaded from the next binary value, so the Gray output comes straight from a flop with no logic between it and the crossing. A zero-based storage index, equal to the binary count minus the window start, addresses the buffer memory. Elaboration is refused for an odd depth, for a depth below two and for a depth above 2^PTR_W. Synchronizing the pointer into another domain is not part of this block.

Top module: `offset_gray_ptr`

## Requirements
- R1: While reset is asserted, and after it is released with no increment, `ptr_bin_o` equals the window start LO = 2^(PTR_W−1) − DEPTH/2, `ptr_gray_o` equals the Gray code of LO and `ptr_idx_o` equals 0.
- R2: A rising clock edge with `inc_i` high and `ptr_bin_o` below the window end HI = 2^(PTR_W−1) + DEPTH/2 − 1 advances `ptr_bin_o` by exactly one.
- R3: A rising clock edge with `inc_i` low leaves all three outputs unchanged.
- R4: A rising clock edge with `inc_i` high and `ptr_bin_o` equal to HI loads LO into `ptr_bin_o`.
- R5: At every clock edge `ptr_gray_o` bit y equals `ptr_bin_o` bit y XOR bit y+1, and its top bit equals the top binary bit. Both outputs update in the same cycle.
- R6: Every increment, the wrap from HI to LO included, changes exactly one bit of `ptr_gray_o`.
- R7: `ptr_idx_o` equals `ptr_bin_o` − LO and always lies in 0 to DEPTH−1.
- R8: `ptr_bin_o` never lies outside LO..HI.
- R9: With the default DEPTH = 688 and PTR_W = 10, LO is 168, HI is 855, the Gray code at LO is 10'b0011111100 and the Gray code at HI is 10'b1011111100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance the pointer by one position at this edge |
| ptr_gray_o | output | PTR_W | Registered Gray pointer, ready to cross domains |
| ptr_bin_o | output | PTR_W | Registered binary pointer inside the offset window |
| ptr_idx_o | output | IDX_W | Zero-based storage index, 0 to DEPTH−1 |

## Verification
The increment is driven in three patterns. Long runs with the enable low show that the hold path keeps all three outputs steady. A random enable at about seventy percent density mixes steps and stalls at arbitrary positions, which separates a correct step from a skip or a double step. A continuous enable run of more than one full lap lands exactly on HI and crosses the wrap. That run is what tells the offset window apart from a counter that wraps at 2^N or starts at zero, because only the centred window keeps the wrap to a single Gray bit and gives the stated codes at 168 and 855.

// File: rtl/gptr_pkg.sv
package gptr_pkg;

  // Reflected binary code of a value of up to 32 bits.
  function automatic logic [31:0] gptr_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // First binary code of a window of depth d centred in a 2^w space.
  function automatic int gptr_win_lo(input int w, input int d);
    return (1 << (w - 1)) - (d / 2);
  endfunction

  // Last binary code of the same window.
  function automatic int gptr_win_hi(input int w, input int d);
    return (1 << (w - 1)) + (d / 2) - 1;
  endfunction

endpackage

// File: rtl/gptr_bin_counter.sv
module gptr_bin_counter #(
  parameter int PTR_W = 10,
  parameter logic [PTR_W-1:0] LO = '0,
  parameter logic [PTR_W-1:0] HI = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [PTR_W-1:0] bin_q,
  output logic [PTR_W-1:0] bin_next,
  output logic             wrap_evt
);

  logic at_top;

  assign at_top   = (bin_q == HI);
  assign wrap_evt = inc_i && at_top;

  always_comb begin
    bin_next = bin_q;
    if (inc_i) begin
      if (at_top) bin_next = LO;
      else        bin_next = bin_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_q <= LO;
    else        bin_q <= bin_next;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && bin_q != HI) |=> (bin_q == $past(bin_q) + PTR_W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(bin_q));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (bin_q == LO));

  assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q >= LO) && (bin_q <= HI));

endmodule

// File: rtl/gptr_gray_reg.sv
module gptr_gray_reg #(
  parameter int PTR_W = 10,
  parameter logic [PTR_W-1:0] RST_BIN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] bin_next_i,
  output logic [PTR_W-1:0] gray_q
);
  import gptr_pkg::*;

  localparam logic [PTR_W-1:0] RST_GRAY = PTR_W'(gptr_to_gray(32'(RST_BIN)));

  logic [PTR_W-1:0] gray_next;

  // Conversion sits before the flop, so the crossing sees a pure flop output.
  assign gray_next = PTR_W'(gptr_to_gray(32'(bin_next_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_q <= RST_GRAY;
    else        gray_q <= gray_next;
  end

endmodule

// File: rtl/gptr_index.sv
module gptr_index #(
  parameter int PTR_W = 10,
  parameter int IDX_W = 10,
  parameter logic [PTR_W-1:0] LO = '0
) (
  input  logic [PTR_W-1:0] bin_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [PTR_W-1:0] diff;

  assign diff  = bin_i - LO;
  assign idx_o = IDX_W'(diff);

endmodule

// File: rtl/offset_gray_ptr.sv
module offset_gray_ptr #(
  parameter int DEPTH = 688,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_gray_o,
  output logic [PTR_W-1:0] ptr_bin_o,
  output logic [IDX_W-1:0] ptr_idx_o
);
  import gptr_pkg::*;

  localparam logic [PTR_W-1:0] WIN_LO = PTR_W'(gptr_win_lo(PTR_W, DEPTH));
  localparam logic [PTR_W-1:0] WIN_HI = PTR_W'(gptr_win_hi(PTR_W, DEPTH));

  generate
    if ((DEPTH % 2) != 0) begin : g_err_odd
      $error("offset_gray_ptr: DEPTH must be even");
    end
    if (DEPTH < 2) begin : g_err_small
      $error("offset_gray_ptr: DEPTH must be at least 2");
    end
    if (DEPTH > (1 << PTR_W)) begin : g_err_wide
      $error("offset_gray_ptr: DEPTH exceeds 2^PTR_W");
    end
  endgenerate

  logic [PTR_W-1:0] bin_next;
  logic             wrap_evt;
  logic             inc_evt;

  assign inc_evt = inc_i;

  gptr_bin_counter #(
    .PTR_W (PTR_W),
    .LO    (WIN_LO),
    .HI    (WIN_HI)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (inc_i),
    .bin_q    (ptr_bin_o),
    .bin_next (bin_next),
    .wrap_evt (wrap_evt)
  );

  gptr_gray_reg #(
    .PTR_W   (PTR_W),
    .RST_BIN (WIN_LO)
  ) u_gray (
    .clk        (clk),
    .rst_n      (rst_n),
    .bin_next_i (bin_next),
    .gray_q     (ptr_gray_o)
  );

  gptr_index #(
    .PTR_W (PTR_W),
    .IDX_W (IDX_W),
    .LO    (WIN_LO)
  ) u_idx (
    .bin_i (ptr_bin_o),
    .idx_o (ptr_idx_o)
  );

  assert_gray_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_gray_o == PTR_W'(gptr_to_gray(32'(ptr_bin_o))));

  assert_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> ($countones(ptr_gray_o ^ $past(ptr_gray_o)) == 1));

  assert_wrap_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ((ptr_gray_o ^ $past(ptr_gray_o)) == {1'b1, {(PTR_W-1){1'b0}}}));

  assert_gray_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_evt |=> $stable(ptr_gray_o));

  assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_idx_o) < DEPTH);

endmodule

// File: tb/test_offset_gray_ptr.sv
module test_offset_gray_ptr;

  localparam int DEPTH = 688;
  localparam int W     = 10;
  localparam int IW    = 10;
  localparam int LO    = 168;
  localparam int HI    = 855;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inc_i = 1'b0;
  logic [W-1:0]  ptr_gray_o;
  logic [W-1:0]  ptr_bin_o;
  logic [IW-1:0] ptr_idx_o;

  int checks = 0;
  int errors = 0;
  int exp_bin = LO;
  int wraps = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  offset_gray_ptr #(.DEPTH(DEPTH)) i_offset_gray_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc_i),
    .ptr_gray_o (ptr_gray_o),
    .ptr_bin_o  (ptr_bin_o),
    .ptr_idx_o  (ptr_idx_o)
  );

  function automatic logic [W-1:0] ref_gray(input int b);
    logic [W-1:0] v;
    logic [W-1:0] g;
    v = W'(b);
    g[W-1] = v[W-1];
    for (int i = 0; i < W - 1; i++) g[i] = v[i] ^ v[i+1];
    return g;
  endfunction

  function automatic int ones(input logic [W-1:0] x);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(x[i]);
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " bin"}, int'(ptr_bin_o), exp_bin);
    chk("R5 gray", int'(ptr_gray_o), int'(ref_gray(exp_bin)));
    chk("R7 index", int'(ptr_idx_o), exp_bin - LO);
    chk("R8 in window", int'(ptr_bin_o >= W'(LO) && ptr_bin_o <= W'(HI)), 1);
  endtask

  task automatic step(input bit en);
    logic [W-1:0] g_before;
    int prev;
    g_before = ptr_gray_o;
    prev = exp_bin;
    inc_i = en;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      if (exp_bin == HI) begin exp_bin = LO; wraps++; end
      else exp_bin = exp_bin + 1;
    end
    if (!en) chk_all("R3 hold");
    else if (prev == HI) chk_all("R4 wrap");
    else chk_all("R2 step");
    chk("R6 gray bits changed", ones(ptr_gray_o ^ g_before), en ? 1 : 0);
    if (en && prev == HI) begin
      chk("R9 gray before wrap", int'(g_before), 10'b1011111100);
      chk("R9 gray after wrap", int'(ptr_gray_o), 10'b0011111100);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    @(negedge clk);
    chk("R1 bin in reset", int'(ptr_bin_o), LO);
    chk("R1 gray in reset", int'(ptr_gray_o), int'(ref_gray(LO)));
    chk("R1 index in reset", int'(ptr_idx_o), 0);
    chk("R9 reset gray code", int'(ptr_gray_o), 10'b0011111100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bin after release", int'(ptr_bin_o), LO);
    chk("R1 index after release", int'(ptr_idx_o), 0);

    // directed hold run
    for (int i = 0; i < 8; i++) step(1'b0);
    // single steps and stalls
    step(1'b1); step(1'b0); step(1'b1); step(1'b1); step(1'b0);

    // random enable, about 70 percent
    for (int i = 0; i < 3000; i++) step(($urandom % 10) < 7);

    // continuous run across at least one full lap
    for (int i = 0; i < DEPTH + 20; i++) begin
      step(1'b1);
      if (exp_bin == HI) begin
        chk("R9 window end bin", int'(ptr_bin_o), 855);
        chk("R9 window end gray", int'(ptr_gray_o), 10'b1011111100);
        chk("R7 index at end", int'(ptr_idx_o), DEPTH - 1);
      end
    end
    chk("R4 wrap observed", int'(wraps > 0), 1);

    // stall exactly on the window end, then wrap
    while (exp_bin != HI) step(1'b1);
    for (int i = 0; i < 4; i++) step(1'b0);
    step(1'b1);
    chk("R4 bin after wrap", int'(ptr_bin_o), LO);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule